// File: doc/BRIEF.md
# Supply-Line Pulse-Width Command Decoder

This block receives commands that a programming station sends by modulating the supply rail of a two-wire sensor. An analog comparator reduces the rail to one bit, high or low. The decoder measures, in ticks of a slow timebase, how long each high phase and each low phase lasts. It turns every pulse into one data bit. A bit is a one when its high phase outlasts its low phase. The bits are gathered into 13-bit words. The first bit received lands in bit 0. A fourteenth pulse acts as the stop bit, and a low phase that runs past a threshold closes the word.

Each pulse also clocks one reply bit out of the sensor. The reply appears on an open-drain pull-down, so a reply of 0 pulls the line low. The decoder only listens after a test-mode entry. After reset the output stays released while the block watches the sensed output pin. If an external tool holds the pin low for long enough inside the entry window, test mode starts, provided the part is not already programmed. A supply high that lasts too long ends the session. Only a new reset can reopen test mode.

Top module: `swd_decoder`

## Requirements
- R1: After reset `test_mode`, `rx_valid` and `q_pull_low` are 0.
- R2: With `programmed` low, holding `pin_low` high for ENTRY_TICKS consecutive ticks, before WINDOW_TICKS ticks have passed since reset, raises `test_mode`. A cycle with `pin_low` low restarts the run.
- R3: If `programmed` is high while the block watches for entry, or if the window ends first, `test_mode` stays 0 until the next reset.
- R4: A pulse is decoded as 1 when its high time in ticks is strictly greater than its low time, which runs up to the next rising edge. Otherwise it is decoded as 0. Equal times give 0.
- R5: Bit k of `rx_word` is the value of the k-th data pulse of the word, counting from 0. Thirteen data pulses are followed by one stop pulse.
- R6: When the supply stays low for EOW_TICKS ticks after a pulse, the word ends. If at least 13 data pulses came before the stop pulse, `rx_valid` pulses for exactly one cycle and `rx_word` takes the new word. Otherwise there is no strobe and `rx_word` keeps its value.
- R7: When more than 14 pulses form one word, the 13 data pulses that come just before the stop pulse are the ones kept.
- R8: Pulse p of a word, counted from 0 for p below 13, drives `q_pull_low` to the inverse of `reply_word[p]`. `reply_word` is sampled at pulse 0. Later pulses, and the time after the word ends, leave the line released.
- R9: A supply high that lasts EOC_TICKS ticks drops `test_mode`. Entry is then refused until reset.
- R10: A rising edge that arrives on the very tick that would complete the end-of-word low counts as a pulse. It does not end the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle timebase strobe |
| sup_hi | input | 1 | Supply comparator: 1 while the rail is in its high band |
| pin_low | input | 1 | Sensed output pin reads low |
| programmed | input | 1 | Device already programmed, entry refused |
| reply_word | input | 13 | Reply bits, sent LSB first |
| rx_word | output | 13 | Last complete received word |
| rx_valid | output | 1 | One-cycle strobe for a new word |
| test_mode | output | 1 | Test session active |
| q_pull_low | output | 1 | Open-drain pull-down for reply bits |

## Verification
The rising edge that closes a bit and the end-of-word timeout can fall in the same cycle. This happens when a pulse follows a low phase that is exactly one tick short of the timeout. The bench provokes this by counting EOW_TICKS-1 ticks of low and then raising the supply in the cycle that carries the next tick. It then expects one strobe for the whole word, with that bit read as 0. A reference model updated on every clock judges the same cycles independently. The model also covers the fact that every rising edge both closes the previous bit and shifts out the next reply bit.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic [1:0] {
        ENT_WATCH  = 2'd0,
        ENT_ACTIVE = 2'd1,
        ENT_LOCKED = 2'd2
    } entry_state_e;

    typedef struct packed {
        logic bit_stb;
        logic bit_val;
        logic pulse;
        logic eow;
        logic eoc;
    } line_evt_t;

endpackage

// File: rtl/swd_entry.sv
module swd_entry
    import swd_pkg::*;
#(
    parameter int ENTRY_TICKS  = 1000,
    parameter int WINDOW_TICKS = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic pin_low,
    input  logic programmed,
    input  logic eoc,
    output logic test_mode
);
    localparam int RW = $clog2(ENTRY_TICKS + 1);
    localparam int WW = $clog2(WINDOW_TICKS + 1);

    typedef struct packed {
        entry_state_e  st;
        logic [RW-1:0] run;
        logic [WW-1:0] win;
    } entry_reg_t;

    entry_reg_t r_q, r_d;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ENT_WATCH: begin
                if (programmed) begin
                    r_d.st = ENT_LOCKED;
                end else begin
                    if (!pin_low) begin
                        r_d.run = '0;
                    end else if (tick) begin
                        if (r_q.run == RW'(ENTRY_TICKS - 1)) r_d.st = ENT_ACTIVE;
                        else r_d.run = r_q.run + 1'b1;
                    end
                    if (tick && r_d.st == ENT_WATCH) begin
                        if (r_q.win == WW'(WINDOW_TICKS - 1)) r_d.st = ENT_LOCKED;
                        else r_d.win = r_q.win + 1'b1;
                    end
                end
            end
            ENT_ACTIVE: begin
                if (eoc) r_d.st = ENT_LOCKED;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= ENT_WATCH;
            r_q.run <= '0;
            r_q.win <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign test_mode = (r_q.st == ENT_ACTIVE);

endmodule

// File: rtl/swd_meter.sv
module swd_meter
    import swd_pkg::*;
#(
    parameter int EOW_TICKS = 300,
    parameter int EOC_TICKS = 600
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      active,
    input  logic      tick,
    input  logic      sup_hi,
    output line_evt_t evt
);
    localparam int TMAX = (EOW_TICKS > EOC_TICKS) ? EOW_TICKS : EOC_TICKS;
    localparam int CW   = $clog2(TMAX + 1);

    typedef struct packed {
        logic          prev;
        logic          seen;
        logic          pend;
        logic [CW-1:0] hi;
        logic [CW-1:0] hilen;
        logic [CW-1:0] lo;
        line_evt_t     evt;
    } meter_reg_t;

    meter_reg_t r_q, r_d;
    logic rise, fall;

    always_comb begin
        r_d      = r_q;
        r_d.evt  = '0;
        r_d.prev = sup_hi;
        rise     = sup_hi & ~r_q.prev;
        fall     = ~sup_hi & r_q.prev;
        if (!active) begin
            r_d.seen  = 1'b0;
            r_d.pend  = 1'b0;
            r_d.hi    = '0;
            r_d.hilen = '0;
            r_d.lo    = '0;
        end else if (rise) begin
            if (r_q.pend) begin
                r_d.evt.bit_stb = 1'b1;
                r_d.evt.bit_val = (r_q.hilen > r_q.lo);
            end
            r_d.pend      = 1'b0;
            r_d.evt.pulse = 1'b1;
            r_d.hi        = '0;
            r_d.seen      = 1'b1;
        end else if (fall && r_q.seen) begin
            r_d.hilen = r_q.hi;
            r_d.lo    = '0;
            r_d.pend  = 1'b1;
        end else if (tick) begin
            if (sup_hi && r_q.seen) begin
                if (r_q.hi == CW'(EOC_TICKS - 1)) r_d.evt.eoc = 1'b1;
                else r_d.hi = r_q.hi + 1'b1;
            end else if (!sup_hi && r_q.pend) begin
                if (r_q.lo == CW'(EOW_TICKS - 1)) begin
                    r_d.evt.eow = 1'b1;
                    r_d.pend    = 1'b0;
                end else begin
                    r_d.lo = r_q.lo + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign evt = r_q.evt;

endmodule

// File: rtl/swd_wordbuf.sv
module swd_wordbuf #(
    parameter int DATA_BITS = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 active,
    input  logic                 bit_stb,
    input  logic                 bit_val,
    input  logic                 pulse,
    input  logic                 eow,
    input  logic [DATA_BITS-1:0] reply_word,
    output logic [DATA_BITS-1:0] rx_word,
    output logic                 rx_valid,
    output logic                 q_pull_low
);
    localparam int PW = $clog2(DATA_BITS + 1);

    typedef struct packed {
        logic [DATA_BITS-1:0] sh;
        logic [PW-1:0]        cnt;
        logic [DATA_BITS-1:0] word;
        logic                 valid;
        logic [PW-1:0]        rptr;
        logic [DATA_BITS-1:0] rdata;
        logic                 drive;
    } buf_reg_t;

    buf_reg_t r_q, r_d;
    logic [DATA_BITS-1:0] src;

    always_comb begin
        r_d = r_q;
        src = (r_q.rptr == '0) ? reply_word : r_q.rdata;
        if (!active) begin
            r_d.sh    = '0;
            r_d.cnt   = '0;
            r_d.valid = 1'b0;
            r_d.rptr  = '0;
            r_d.drive = 1'b0;
        end else begin
            r_d.valid = 1'b0;
            if (eow) begin
                if (r_q.cnt == PW'(DATA_BITS)) begin
                    r_d.valid = 1'b1;
                    r_d.word  = r_q.sh;
                end
                r_d.sh    = '0;
                r_d.cnt   = '0;
                r_d.rptr  = '0;
                r_d.drive = 1'b0;
            end
            if (bit_stb) begin
                r_d.sh = {bit_val, r_q.sh[DATA_BITS-1:1]};
                if (r_q.cnt != PW'(DATA_BITS)) r_d.cnt = r_q.cnt + 1'b1;
            end
            if (pulse) begin
                if (r_q.rptr < PW'(DATA_BITS)) begin
                    r_d.drive = ~src[0];
                    r_d.rdata = src >> 1;
                    r_d.rptr  = r_q.rptr + 1'b1;
                end else begin
                    r_d.drive = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign rx_word    = r_q.word;
    assign rx_valid   = r_q.valid;
    assign q_pull_low = r_q.drive;

endmodule

// File: rtl/swd_decoder.sv
module swd_decoder
    import swd_pkg::*;
#(
    parameter int DATA_BITS    = 13,
    parameter int ENTRY_TICKS  = 1000,
    parameter int WINDOW_TICKS = 5000,
    parameter int EOW_TICKS    = 300,
    parameter int EOC_TICKS    = 600
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 sup_hi,
    input  logic                 pin_low,
    input  logic                 programmed,
    input  logic [DATA_BITS-1:0] reply_word,
    output logic [DATA_BITS-1:0] rx_word,
    output logic                 rx_valid,
    output logic                 test_mode,
    output logic                 q_pull_low
);
    line_evt_t evt;
    logic      tm;

    swd_entry #(
        .ENTRY_TICKS (ENTRY_TICKS),
        .WINDOW_TICKS(WINDOW_TICKS)
    ) u_entry (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .pin_low   (pin_low),
        .programmed(programmed),
        .eoc       (evt.eoc),
        .test_mode (tm)
    );

    swd_meter #(
        .EOW_TICKS(EOW_TICKS),
        .EOC_TICKS(EOC_TICKS)
    ) u_meter (
        .clk   (clk),
        .rst_n (rst_n),
        .active(tm),
        .tick  (tick),
        .sup_hi(sup_hi),
        .evt   (evt)
    );

    swd_wordbuf #(
        .DATA_BITS(DATA_BITS)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (tm),
        .bit_stb   (evt.bit_stb),
        .bit_val   (evt.bit_val),
        .pulse     (evt.pulse),
        .eow       (evt.eow),
        .reply_word(reply_word),
        .rx_word   (rx_word),
        .rx_valid  (rx_valid),
        .q_pull_low(q_pull_low)
    );

    assign test_mode = tm;

endmodule

// File: rtl/swd_decoder_chk.sv
module swd_decoder_chk #(
    parameter int DATA_BITS = 13
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 programmed,
    input logic                 test_mode,
    input logic                 rx_valid,
    input logic [DATA_BITS-1:0] rx_word,
    input logic                 q_pull_low
);
    logic tm_prev_q, left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_prev_q <= 1'b0;
            left_q    <= 1'b0;
        end else begin
            tm_prev_q <= test_mode;
            if (tm_prev_q && !test_mode) left_q <= 1'b1;
        end
    end

    assert_valid_in_test_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> test_mode);

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> $stable(rx_word));

    assert_prog_refuse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(test_mode) |-> !$past(programmed));

    assert_no_reentry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        left_q |-> !test_mode);

    assert_drive_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
        q_pull_low |-> (test_mode || $past(test_mode)));

endmodule

bind swd_decoder swd_decoder_chk #(.DATA_BITS(DATA_BITS)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .programmed(programmed),
    .test_mode (test_mode),
    .rx_valid  (rx_valid),
    .rx_word   (rx_word),
    .q_pull_low(q_pull_low)
);

// File: tb/swd_decoder_test.sv
module swd_decoder_test;
    localparam int DB  = 13;
    localparam int ENT = 10;
    localparam int WIN = 40;
    localparam int EOW = 20;
    localparam int EOC = 40;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic          sup_hi = 1'b0;
    logic          pin_low = 1'b0;
    logic          programmed = 1'b0;
    logic [DB-1:0] reply_word = '0;
    logic [DB-1:0] rx_word;
    logic          rx_valid, test_mode, q_pull_low;

    swd_decoder #(
        .DATA_BITS(DB), .ENTRY_TICKS(ENT), .WINDOW_TICKS(WIN),
        .EOW_TICKS(EOW), .EOC_TICKS(EOC)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sup_hi(sup_hi),
        .pin_low(pin_low), .programmed(programmed), .reply_word(reply_word),
        .rx_word(rx_word), .rx_valid(rx_valid), .test_mode(test_mode),
        .q_pull_low(q_pull_low)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int div = 0;
    always @(negedge clk) begin
        div  = (div == 3) ? 0 : div + 1;
        tick = (div == 0);
    end

    // behavioural reference model
    int m_st, m_run, m_win, m_hi, m_hl, m_lo, m_rptr, m_total;
    bit m_prev, m_seen, m_pend, m_valid, m_drive;
    bit e_bit, e_val, e_pulse, e_eow, e_eoc;
    logic [DB-1:0] m_word, m_rl;
    bit bits[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_run = 0; m_win = 0; m_hi = 0; m_hl = 0; m_lo = 0;
            m_rptr = 0; m_total = 0; m_prev = 0; m_seen = 0; m_pend = 0;
            m_valid = 0; m_drive = 0; m_word = '0; m_rl = '0;
            e_bit = 0; e_val = 0; e_pulse = 0; e_eow = 0; e_eoc = 0;
            bits.delete();
        end else begin
            automatic bit act = (m_st == 1);
            automatic bit rise = sup_hi && !m_prev;
            automatic bit fall = !sup_hi && m_prev;
            automatic bit nb = 0, nv = 0, np = 0, nw = 0, nc = 0;
            // word and reply side
            m_valid = 0;
            if (!act) begin
                m_drive = 0; m_rptr = 0; m_total = 0; bits.delete();
            end else begin
                if (e_eow) begin
                    if (m_total >= DB) begin
                        m_valid = 1;
                        for (int i = 0; i < DB; i++) m_word[i] = bits[i];
                    end
                    bits.delete(); m_total = 0; m_rptr = 0; m_drive = 0;
                end
                if (e_bit) begin
                    bits.push_back(e_val);
                    if (bits.size() > DB) void'(bits.pop_front());
                    m_total++;
                end
                if (e_pulse) begin
                    if (m_rptr == 0) m_rl = reply_word;
                    if (m_rptr < DB) begin m_drive = !m_rl[m_rptr]; m_rptr++; end
                    else m_drive = 0;
                end
            end
            // entry
            if (m_st == 0) begin
                if (programmed) m_st = 2;
                else begin
                    if (!pin_low) m_run = 0;
                    else if (tick) begin
                        if (m_run == ENT - 1) m_st = 1; else m_run++;
                    end
                    if (tick && m_st == 0) begin
                        if (m_win == WIN - 1) m_st = 2; else m_win++;
                    end
                end
            end else if (m_st == 1 && e_eoc) m_st = 2;
            // line timing
            if (!act) begin
                m_seen = 0; m_pend = 0; m_hi = 0; m_hl = 0; m_lo = 0;
            end else if (rise) begin
                if (m_pend) begin nb = 1; nv = (m_hl > m_lo); end
                m_pend = 0; np = 1; m_hi = 0; m_seen = 1;
            end else if (fall && m_seen) begin
                m_hl = m_hi; m_lo = 0; m_pend = 1;
            end else if (tick) begin
                if (sup_hi && m_seen) begin
                    if (m_hi == EOC - 1) nc = 1; else m_hi++;
                end else if (!sup_hi && m_pend) begin
                    if (m_lo == EOW - 1) begin nw = 1; m_pend = 0; end else m_lo++;
                end
            end
            m_prev = sup_hi;
            e_bit = nb; e_val = nv; e_pulse = np; e_eow = nw; e_eoc = nc;
        end
    end

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    int valid_cnt = 0;
    logic [DB-1:0] last_word = '0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2", "model test_mode", 32'(test_mode), 32'(m_st == 1));
            chk("R6", "model rx_valid", 32'(rx_valid), 32'(m_valid));
            chk("R5", "model rx_word", 32'(rx_word), 32'(m_word));
            chk("R8", "model q_pull_low", 32'(q_pull_low), 32'(m_drive));
            if (rx_valid) begin valid_cnt++; last_word = rx_word; end
        end
    end

    task automatic wait_ticks(int n);
        int c = 0;
        while (c < n) begin
            @(posedge clk);
            if (tick) c++;
        end
        @(negedge clk); #1;
    endtask

    task automatic do_reset();
        rst_n = 0; sup_hi = 0; pin_low = 0; programmed = 0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
    endtask

    task automatic send_pulse(int hi, int lo, bit exp_low, bit align);
        sup_hi = 1;
        wait_ticks(hi);
        chk("R8", "reply drive", 32'(q_pull_low), 32'(exp_low));
        sup_hi = 0;
        wait_ticks(lo);
        if (align) while (!tick) begin @(negedge clk); #1; end
    endtask

    // lead: junk '1' pulses before data; align_idx: data bit sent as '0' with low EOW-1 aligned on a tick
    task automatic send_word(logic [DB-1:0] w, int lead, int align_idx);
        int p = 0;
        for (int i = 0; i < lead; i++) begin
            send_pulse(8, 4, (p < DB) ? !reply_word[p] : 1'b0, 0); p++;
        end
        for (int i = 0; i < DB; i++) begin
            bit ex = (p < DB) ? !reply_word[p] : 1'b0;
            if (i == align_idx) send_pulse(4, EOW - 1, ex, 1);
            else if (w[i]) send_pulse(8, 4, ex, 0);
            else send_pulse(4, 8, ex, 0);
            p++;
        end
        send_pulse(4, EOW + 3, 1'b0, 0);
    endtask

    task automatic summary();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int vc;
        do_reset();
        @(negedge clk); #1;
        chk("R1", "reset test_mode", 32'(test_mode), 0);
        chk("R1", "reset rx_valid", 32'(rx_valid), 0);
        chk("R1", "reset q_pull_low", 32'(q_pull_low), 0);

        // programmed part refuses entry
        programmed = 1; pin_low = 1;
        wait_ticks(15);
        chk("R3", "programmed refuses", 32'(test_mode), 0);
        do_reset();

        // broken run, then window expires
        pin_low = 1; wait_ticks(5); pin_low = 0;
        wait_ticks(45);
        pin_low = 1; wait_ticks(15);
        chk("R3", "window expired", 32'(test_mode), 0);
        do_reset();

        // entry
        pin_low = 1;
        wait_ticks(ENT - 1);
        chk("R2", "not yet entered", 32'(test_mode), 0);
        wait_ticks(2);
        chk("R2", "entered", 32'(test_mode), 1);
        pin_low = 0;

        reply_word = 13'h0F3C;
        send_word(13'h1A5B, 0, -1);
        chk("R6", "strobe count", 32'(valid_cnt), 1);
        chk("R5", "word value", 32'(last_word), 32'h1A5B);

        // short word: no strobe, word held
        for (int i = 0; i < 5; i++) send_pulse(8, 4, !reply_word[i], 0);
        send_pulse(4, EOW + 3, !reply_word[5], 0);
        chk("R6", "short word no strobe", 32'(valid_cnt), 1);
        chk("R6", "short word hold", 32'(rx_word), 32'h1A5B);

        // near-threshold classification
        reply_word = 13'h1555;
        send_pulse(7, 6, !reply_word[0], 0);
        send_pulse(6, 6, !reply_word[1], 0);
        for (int i = 2; i < DB; i++) send_pulse(4, 8, !reply_word[i], 0);
        send_pulse(4, EOW + 3, 1'b0, 0);
        chk("R4", "7/6 is one, 6/6 is zero", 32'(last_word), 32'h0001);
        chk("R4", "strobe count", 32'(valid_cnt), 2);

        // overrun keeps the newest 13
        reply_word = 13'h0A0F;
        send_word(13'h0C3A, 4, -1);
        chk("R7", "overrun word", 32'(last_word), 32'h0C3A);
        chk("R7", "overrun strobe", 32'(valid_cnt), 3);

        // rising edge on the end-of-word tick
        vc = valid_cnt;
        send_word(13'h1FF7 & ~13'h0008, 0, 3);
        chk("R10", "single strobe", 32'(valid_cnt), 32'(vc + 1));
        chk("R10", "aligned bit reads zero", 32'(last_word), 32'h1FF7);

        // end of communication
        sup_hi = 1;
        wait_ticks(EOC + 3);
        chk("R9", "session closed", 32'(test_mode), 0);
        sup_hi = 0; pin_low = 1;
        wait_ticks(ENT + 5);
        chk("R9", "no re-entry", 32'(test_mode), 0);
        chk("R8", "released after close", 32'(q_pull_low), 0);
        pin_low = 0;
        repeat (4) @(negedge clk);
        summary();
    end

endmodule